// File: doc/BRIEF.md
# Daisy-Chained Bus Grant Chain

This block holds the bus-access nodes of a group of devices that share one bus. A central arbiter drives a single grant wire into the first node. Each node passes that wire on to the next, lower-priority node. All nodes share one request line and one release line back to the arbiter, each line formed as the OR of every node's contribution. A device that wants the bus raises its local request. Its node then drives the shared request and waits for a fresh low-to-high transition on the grant arriving from upstream.

When that edge arrives, the node keeps the grant from travelling further and drops its request. It then tells the local logic that the bus is owned. When the local logic signals that it is done, the node emits a one-clock release pulse. The grant stays blocked until the arbiter has taken the grant away. A node that is not waiting for the bus passes the grant through combinationally. The node closest to the arbiter therefore wins whenever several nodes are waiting at the same edge.

Top module: `dgc_chain`

## Requirements
- R1: Under synchronous active-high reset every node returns to idle: `dev_owned`, `bus_req` and `bus_release` are all 0, and `grant_tail` follows `grant_in`.
- R2: A node that is idle, or is not catching a grant edge, forwards its incoming grant to its outgoing grant in the same cycle.
- R3: A local request pulse seen by an idle node raises `bus_req` at the next clock edge. The request stays high even after the local request drops, until the node claims the bus.
- R4: A waiting node claims the bus only on a rising transition of its incoming grant, meaning the grant is 1 now and was 0 in the previous cycle. A grant that is already high when the request begins is forwarded and not claimed.
- R5: In the cycle of the claiming edge, the node's outgoing grant is already 0. From the next edge the node's `dev_owned` bit is 1, its request contribution is 0, and its outgoing grant stays 0 for the whole ownership.
- R6: When several nodes are waiting at the same grant edge, the node with the lowest index wins. Index 0 is nearest the arbiter.
- R7: A done input seen while the node owns the bus ends ownership at the next edge. `dev_owned` falls and `bus_release` is high for exactly one cycle.
- R8: After release, the node keeps its outgoing grant at 0 until its incoming grant has been low for a cycle. Only then does a later grant pass through.
- R9: A done input on a node that does not own the bus has no effect. A local request on a node that is waiting or owning starts nothing new.
- R10: At most one bit of `dev_owned` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| grant_in | input | 1 | Grant from the arbiter into node 0 |
| dev_req | input | NODES | Local request per device |
| dev_done | input | NODES | Local end-of-use per device |
| dev_owned | output | NODES | Bus owned per device |
| bus_req | output | 1 | OR of all node requests, to the arbiter |
| bus_release | output | 1 | OR of all node release pulses, to the arbiter |
| grant_tail | output | 1 | Grant leaving the last node; high means no node took it |

## Verification
The assertions assume an arbiter that raises grant only while `bus_req` is high, lowers it after a release pulse or when the grant reaches the tail unclaimed, and never lowers it during ownership. They also assume done is only meaningful while owned. The bench drives the directed part with a hand-stepped grant that obeys these rules. The random part drives the grant from a small registered arbiter model that follows the same rules. Random local requests and done bits are applied to all nodes, including done on nodes that do not own the bus.

// File: rtl/dgc_pkg.sv
package dgc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_OWN  = 2'd2,
    ST_FREE = 2'd3
  } node_st_t;
endpackage

// File: rtl/dgc_wor.sv
module dgc_wor #(
  parameter int W = 4
) (
  input  logic [W-1:0] bits,
  output logic         y
);
  assign y = |bits;
endmodule

// File: rtl/dgc_node.sv
module dgc_node
  import dgc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic gin,
  input  logic lreq,
  input  logic ldone,
  output logic gout,
  output logic breq,
  output logic owned,
  output logic rel
);
  node_st_t state_q, state_d;
  logic     gprev_q;
  logic     hold_q;
  logic     claim;

  // rising grant edge while waiting
  assign claim = (state_q == ST_WAIT) && gin && !gprev_q;
  assign gout  = gin && !hold_q && !claim;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (lreq)  state_d = ST_WAIT;
      ST_WAIT: if (claim) state_d = ST_OWN;
      ST_OWN:  if (ldone) state_d = ST_FREE;
      default:            state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      gprev_q <= 1'b0;
      hold_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      gprev_q <= gin;
      if (claim)
        hold_q <= 1'b1;
      else if (!gin && state_q != ST_OWN)
        hold_q <= 1'b0;
    end
  end

  assign breq  = (state_q == ST_WAIT);
  assign owned = (state_q == ST_OWN);
  assign rel   = (state_q == ST_FREE);

  // R7
  release_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    rel |=> !rel);
  // R5
  owner_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    owned |-> !gout);
  // R4
  claim_on_grant_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(owned) |-> $past(gin));
  // R3
  req_held_chk: assert property (@(posedge clk) disable iff (rst)
    breq |=> (breq || owned));
  // R8
  hold_after_rel_chk: assert property (@(posedge clk) disable iff (rst)
    rel |=> !gout);
  // R9
  done_needs_owner_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rel) |-> $past(owned));
endmodule

// File: rtl/dgc_chain.sv
module dgc_chain #(
  parameter int NODES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             grant_in,
  input  logic [NODES-1:0] dev_req,
  input  logic [NODES-1:0] dev_done,
  output logic [NODES-1:0] dev_owned,
  output logic             bus_req,
  output logic             bus_release,
  output logic             grant_tail
);
  localparam int LINKS = NODES + 1;

  logic [LINKS-1:0] g_link;
  logic [NODES-1:0] req_v;
  logic [NODES-1:0] rel_v;

  assign g_link[0] = grant_in;

  for (genvar i = 0; i < NODES; i++) begin : g_node
    dgc_node node_i (
      .clk   (clk),
      .rst   (rst),
      .gin   (g_link[i]),
      .lreq  (dev_req[i]),
      .ldone (dev_done[i]),
      .gout  (g_link[i+1]),
      .breq  (req_v[i]),
      .owned (dev_owned[i]),
      .rel   (rel_v[i])
    );
  end

  dgc_wor #(.W(NODES)) req_or_i (.bits(req_v), .y(bus_req));
  dgc_wor #(.W(NODES)) rel_or_i (.bits(rel_v), .y(bus_release));

  assign grant_tail = g_link[NODES];

  // R10
  single_owner_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dev_owned));
  // R5
  owner_stops_tail_chk: assert property (@(posedge clk) disable iff (rst)
    (|dev_owned) |-> !grant_tail);
endmodule

// File: tb/dgc_chain_tb.sv
module dgc_chain_tb_top;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         man_mode = 1'b1;
  logic         man_g = 1'b0;
  logic         arb_g;
  logic         grant_in;
  logic [N-1:0] dev_req = '0;
  logic [N-1:0] dev_done = '0;
  logic [N-1:0] dev_owned;
  logic         bus_req, bus_release, grant_tail;

  int checks = 0;
  int failures = 0;
  int releases = 0;

  always #4 clk = ~clk;

  assign grant_in = man_mode ? man_g : arb_g;

  always @(posedge clk) begin
    if (rst || man_mode) arb_g <= 1'b0;
    else if (bus_release || grant_tail) arb_g <= 1'b0;
    else if (!arb_g && bus_req) arb_g <= 1'b1;
  end

  dgc_chain #(.NODES(N)) dut_i (
    .clk(clk), .rst(rst), .grant_in(grant_in), .dev_req(dev_req),
    .dev_done(dev_done), .dev_owned(dev_owned), .bus_req(bus_req),
    .bus_release(bus_release), .grant_tail(grant_tail)
  );

  function automatic int ones(input logic [N-1:0] v);
    int c = 0;
    for (int i = 0; i < N; i++) c += int'(v[i]);
    return c;
  endfunction

  function automatic logic [N-1:0] lowest_bit(input logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return N'(1) << i;
    return '0;
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [N-1:0] p_owned, p_done, exp_w;
    repeat (3) tick();
    rst = 1'b0;
    // R1 reset state
    chk("R1 owned", dev_owned, 0);
    chk("R1 bus_req", bus_req, 0);
    chk("R1 release", bus_release, 0);
    // R2 pass-through with no requests
    man_g = 1'b1; #1;
    chk("R2 tail follows", grant_tail, 1);
    tick();
    // R4 request while grant already high: forwarded, not claimed
    dev_req = 4'b0100; tick(); dev_req = '0;
    chk("R3 bus_req raised", bus_req, 1);
    tick(); tick();
    chk("R3 request held", bus_req, 1);
    chk("R4 no claim on high level", dev_owned, 0);
    chk("R2 forward while waiting", grant_tail, 1);
    man_g = 1'b0; tick();
    man_g = 1'b1; #1;
    chk("R5 blocked on edge cycle", grant_tail, 0);
    tick();
    chk("R4 claim on edge", dev_owned, 4'b0100);
    chk("R5 request dropped", bus_req, 0);
    chk("R5 tail low while owned", grant_tail, 0);
    // R9 done on non-owner, request on owner
    dev_done = 4'b0010; dev_req = 4'b0100; tick(); dev_done = '0; dev_req = '0;
    chk("R9 foreign done ignored", dev_owned, 4'b0100);
    chk("R9 no release", bus_release, 0);
    chk("R9 no new request", bus_req, 0);
    // R7 release pulse
    dev_done = 4'b0100; tick(); dev_done = '0;
    chk("R7 release high", bus_release, 1);
    chk("R7 owned falls", dev_owned, 0);
    tick();
    chk("R7 release one cycle", bus_release, 0);
    chk("R8 held while grant high", grant_tail, 0);
    man_g = 1'b0; tick(); tick();
    man_g = 1'b1; #1;
    chk("R8 passes after low", grant_tail, 1);
    // R6 priority
    man_g = 1'b0; dev_req = 4'b1010; tick(); dev_req = '0; tick();
    man_g = 1'b1; tick();
    chk("R6 nearest wins", dev_owned, lowest_bit(4'b1010));
    dev_done = 4'b0010; tick(); dev_done = '0;
    man_g = 1'b0; tick(); tick();
    chk("R3 loser still waiting", bus_req, 1);
    man_g = 1'b1; tick();
    chk("R6 next in line", dev_owned, 4'b1000);
    dev_done = 4'b1000; tick(); dev_done = '0;
    man_g = 1'b0; tick(); tick();
    // random phase with arbiter model
    man_mode = 1'b0;
    void'($urandom(32'd1234));
    p_owned = dev_owned; p_done = '0;
    for (int c = 0; c < 4000; c++) begin
      dev_req  = N'($urandom) & N'($urandom);
      dev_done = N'($urandom);
      p_owned  = dev_owned; p_done = dev_done;
      tick();
      if (bus_release) releases++;
      exp_w = p_owned & p_done;
      if (exp_w != '0) begin
        chk("R7 random release", bus_release, 1);
        chk("R7 random owned falls", dev_owned & exp_w, 0);
      end
      if (ones(dev_owned) > 1) chk("R10 one owner", ones(dev_owned), 1);
      if (dev_owned != '0 && grant_tail) chk("R5 random tail", grant_tail, 0);
    end
    chk("R10 traffic served", releases > 20, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule